// File: doc/BRIEF.md
# Serial Frame Control-Register Slave

This block is the slave end of a synchronous serial link that moves one fixed 64-bit word per frame. Each cycle of the bit clock carries one bit. A one-cycle frame-sync pulse marks bit 0. Inbound, the word carries a 12-bit audio sample and a 14-bit telecom sample, each with its own valid flag. It also carries a 4-bit register address, a direction bit and a 16-bit data field. Outbound, the slave returns its own audio and telecom samples and flags, an echo of the address, and the contents of the addressed register.

Inside sits a bank of sixteen 16-bit control registers. The readback is taken once the address and direction are known, and a write lands only after the last bit of the word has arrived. A frame that writes a register therefore returns the value the register held before that write. Received samples leave on parallel buses with a one-cycle strobe, and only when their flag is set. The outgoing samples are taken from parallel inputs at the start of each frame.

Top module: `sfrm_ctl_slave`

## Requirements
- R1: After reset all sixteen registers read back as zero, `sdo` is 0 and both strobes are low. While no frame is in progress (no `fsync` since reset or since bit 63), `sdo` stays 0.
- R2: Inbound bits 0-11 (bit 0 is the MSB) form the audio sample. When inbound bit 30 is 1, `aud_rx` takes that sample and `aud_rx_stb` is high for exactly one cycle, starting after the rising edge that samples bit 30.
- R3: Inbound bits 32-45 (bit 32 is the MSB) form the telecom sample. When inbound bit 31 is 1, `tel_rx` takes that sample and `tel_rx_stb` is high for one cycle, starting after the rising edge that samples bit 45.
- R4: A strobe is never raised when its flag bit is 0, so no sample is delivered.
- R5: When inbound bit 21 (direction) is 0, outbound bits 48-63 (bit 48 is the MSB) carry the register chosen by inbound bits 17-20 (bit 17 is the MSB). The inbound bits 48-63 of that frame change no register.
- R6: When bit 21 is 1, inbound bits 48-63 are written into the addressed register at the rising edge that samples bit 63. Outbound bits 48-63 of that same frame carry the register's earlier value.
- R7: Outbound bits 17-20 repeat the inbound address bits of the same frame. Outbound bits 12-16, 21-29 and 46-47 are 0.
- R8: Outbound bits 0-11 carry `aud_tx`, bit 30 carries `aud_tx_vld`, bit 31 carries `tel_tx_vld` and bits 32-45 carry `tel_tx`, all MSB first. These values are taken at the rising edge that samples `fsync`.
- R9: A frame-sync pulse before bit 63 starts a new frame at bit 0, and the cut-short frame writes nothing.
- R10: Every frame with bit 21 set writes again, so back-to-back writes to one register each take effect in turn.

Timing: inputs are sampled on the rising edge of `clk`. Outbound bit k is driven from the falling edge that follows the rising edge sampling inbound bit k, and is held for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | One-cycle pulse marking bit 0 of a frame |
| sdi | input | 1 | Serial data into the slave |
| sdo | output | 1 | Serial data out of the slave |
| aud_tx | input | 12 | Audio sample to send |
| aud_tx_vld | input | 1 | Audio valid flag to send |
| tel_tx | input | 14 | Telecom sample to send |
| tel_tx_vld | input | 1 | Telecom valid flag to send |
| aud_rx | output | 12 | Last received audio sample |
| aud_rx_stb | output | 1 | One-cycle strobe for a new audio sample |
| tel_rx | output | 14 | Last received telecom sample |
| tel_rx_stb | output | 1 | One-cycle strobe for a new telecom sample |

## Verification
The tests alternate read frames and write frames on the same and on the edge addresses 0 and 15. This shows whether readback comes from before or after the commit, and whether a read's data field leaks into the bank. Repeated writes of equal and of different values to one register test that every write frame commits. A frame cut short at bit 63, and another at bit 50, each followed at once by a new frame, separate a commit that needs the full word from one that fires early. The sample flags go through all four combinations, with nonzero filler in the reserved inbound bits, so that the bench can see strobes gated by their own flag and zeros in the outbound reserved slots.

// File: rtl/sfrm_ctl_slave.sv
module sfrm_ctl_slave (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fsync,
  input  logic        sdi,
  output logic        sdo,
  input  logic [11:0] aud_tx,
  input  logic        aud_tx_vld,
  input  logic [13:0] tel_tx,
  input  logic        tel_tx_vld,
  output logic [11:0] aud_rx,
  output logic        aud_rx_stb,
  output logic [13:0] tel_rx,
  output logic        tel_rx_stb
);
  localparam logic [6:0] IDLE = 7'd64;

  logic [6:0]        cnt, cur, idx;
  logic              act;
  logic [15:0]       sh, sh_nx, rd;
  logic [15:0][15:0] regs;
  logic [3:0]        addr;
  logic              wr, tflag, lbit;
  logic [11:0]       aud_hold, a_tx;
  logic [13:0]       t_tx;
  logic              a_v, t_v;
  logic [63:0]       ofr;
  logic              obit;

  assign idx   = fsync ? 7'd0 : cnt;
  assign act   = fsync | (cnt < IDLE);
  assign sh_nx = {sh[14:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= IDLE; cur <= IDLE; sh <= '0; rd <= '0; regs <= '0;
      addr <= '0; wr <= 1'b0; tflag <= 1'b0; lbit <= 1'b0;
      aud_hold <= '0; a_tx <= '0; t_tx <= '0; a_v <= 1'b0; t_v <= 1'b0;
      aud_rx <= '0; aud_rx_stb <= 1'b0; tel_rx <= '0; tel_rx_stb <= 1'b0;
    end else begin
      aud_rx_stb <= 1'b0;
      tel_rx_stb <= 1'b0;
      if (act) begin
        cnt  <= idx + 7'd1;
        cur  <= idx;
        sh   <= sh_nx;
        lbit <= sdi;
        case (idx)
          7'd0: begin
            a_tx <= aud_tx; a_v <= aud_tx_vld;
            t_tx <= tel_tx; t_v <= tel_tx_vld;
            wr   <= 1'b0;
          end
          7'd11: aud_hold <= sh_nx[11:0];
          7'd20: addr <= sh_nx[3:0];
          7'd21: begin wr <= sdi; rd <= regs[addr]; end
          7'd30: if (sdi) begin aud_rx <= aud_hold; aud_rx_stb <= 1'b1; end
          7'd31: tflag <= sdi;
          7'd45: if (tflag) begin tel_rx <= sh_nx[13:0]; tel_rx_stb <= 1'b1; end
          7'd63: if (wr) regs[addr] <= sh_nx;
          default: ;
        endcase
      end else begin
        cur <= IDLE;
      end
    end
  end

  assign ofr  = {a_tx, 5'd0, 4'd0, 1'b0, 8'd0, a_v, t_v, t_tx, 2'd0, rd};
  assign obit = cur[6] ? 1'b0 :
                (cur >= 7'd17 && cur <= 7'd20) ? lbit :
                ofr[6'd63 - cur[5:0]];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sdo <= 1'b0;
    else        sdo <= obit;
  end
endmodule

// File: rtl/sfrm_ctl_slave_chk.sv
module sfrm_ctl_slave_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              fsync,
  input logic              sdi,
  input logic              sdo,
  input logic              aud_rx_stb,
  input logic              tel_rx_stb,
  input logic [6:0]        cnt,
  input logic [6:0]        cur,
  input logic              wr,
  input logic              tflag,
  input logic [15:0][15:0] regs
);
  // R2
  aud_stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aud_rx_stb |=> !aud_rx_stb);

  // R3
  tel_stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tel_rx_stb |=> !tel_rx_stb);

  // R4
  aud_flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aud_rx_stb |-> $past(!fsync && cnt == 7'd30 && sdi));

  // R4
  tel_flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tel_rx_stb |-> $past(!fsync && cnt == 7'd45 && tflag));

  // R6
  commit_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $past(!fsync && cnt == 7'd63 && wr));

  // R7
  rsvd_zero_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(cur) >= 7'd64 ||
     ($past(cur) >= 7'd12 && $past(cur) <= 7'd16) ||
     ($past(cur) >= 7'd21 && $past(cur) <= 7'd29) ||
     $past(cur) == 7'd46 || $past(cur) == 7'd47) |-> !sdo);
endmodule

bind sfrm_ctl_slave sfrm_ctl_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdi(sdi), .sdo(sdo),
  .aud_rx_stb(aud_rx_stb), .tel_rx_stb(tel_rx_stb), .cnt(cnt), .cur(cur),
  .wr(wr), .tflag(tflag), .regs(regs)
);

// File: tb/sfrm_ctl_slave_tb.sv
module sfrm_ctl_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [11:0] aud_tx = '0, aud_rx;
  logic [13:0] tel_tx = '0, tel_rx;
  logic aud_tx_vld = 1'b0, tel_tx_vld = 1'b0, aud_rx_stb, tel_rx_stb;

  int checks = 0, errors = 0;
  logic [15:0] mdl [16];
  logic [11:0] aud_q [$];
  logic [13:0] tel_q [$];

  always #2 clk = ~clk;

  sfrm_ctl_slave u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdi(sdi), .sdo(sdo),
    .aud_tx(aud_tx), .aud_tx_vld(aud_tx_vld), .tel_tx(tel_tx), .tel_tx_vld(tel_tx_vld),
    .aud_rx(aud_rx), .aud_rx_stb(aud_rx_stb), .tel_rx(tel_rx), .tel_rx_stb(tel_rx_stb)
  );

  task automatic cmp(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n && aud_rx_stb) begin
      if (aud_q.size() == 0) cmp("R4", "unexpected audio strobe", 16'd1, 16'd0);
      else cmp("R2", "audio sample", {4'd0, aud_rx}, {4'd0, aud_q.pop_front()});
    end
    if (rst_n && tel_rx_stb) begin
      if (tel_q.size() == 0) cmp("R4", "unexpected telecom strobe", 16'd1, 16'd0);
      else cmp("R3", "telecom sample", {2'd0, tel_rx}, {2'd0, tel_q.pop_front()});
    end
  end

  task automatic frame(input int len, input logic [3:0] addr, input logic w, input logic [15:0] wd,
                       input logic [11:0] ai, input logic av, input logic [13:0] ti, input logic tv,
                       input logic [11:0] ao, input logic avo, input logic [13:0] to, input logic tvo,
                       input string dtag);
    logic [63:0] fin, exp, got;
    fin = {ai, 5'b10101, addr, w, 8'hA5, av, tv, ti, 2'b11, wd};
    exp = {ao, 5'd0, addr, 1'b0, 8'd0, avo, tvo, to, 2'd0, mdl[addr]};
    got = '0;
    aud_tx = ao; aud_tx_vld = avo; tel_tx = to; tel_tx_vld = tvo;
    if (av) aud_q.push_back(ai);
    if (tv && len > 45) tel_q.push_back(ti);
    for (int k = 0; k < len; k++) begin
      @(negedge clk); #1;
      if (k > 0) got[64 - k] = sdo;
      fsync = (k == 0);
      sdi = fin[63 - k];
    end
    if (len == 64) begin
      @(negedge clk); #1;
      got[0] = sdo;
      fsync = 1'b0; sdi = 1'b0;
      cmp("R8", "out audio", {4'd0, got[63:52]}, {4'd0, exp[63:52]});
      cmp("R7", "out address echo", {12'd0, got[46:43]}, {12'd0, exp[46:43]});
      cmp("R7", "out reserved", {got[51:47], got[42:34], got[17:16]}, 16'd0);
      cmp("R8", "out flags", {14'd0, got[33:32]}, {14'd0, exp[33:32]});
      cmp("R8", "out telecom", {2'd0, got[31:18]}, {2'd0, exp[31:18]});
      cmp(dtag, "out register data", got[15:0], exp[15:0]);
      if (w) mdl[addr] = wd;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    // R1 reset state and idle output
    cmp("R1", "idle sdo", {15'd0, sdo}, 16'd0);
    cmp("R1", "strobes after reset", {14'd0, aud_rx_stb, tel_rx_stb}, 16'd0);
    // R1 reads of edge addresses, flag combinations for R2 R3 R4 R8
    frame(64, 4'd0,  1'b0, 16'hDEAD, 12'hABC, 1'b1, 14'h2A5A, 1'b1, 12'h123, 1'b1, 14'h1F0F, 1'b0, "R1");
    frame(64, 4'd15, 1'b0, 16'hFFFF, 12'h801, 1'b0, 14'h3FFF, 1'b1, 12'hFFF, 1'b0, 14'h2001, 1'b1, "R1");
    frame(64, 4'd7,  1'b0, 16'h5555, 12'h001, 1'b1, 14'h0001, 1'b0, 12'h800, 1'b1, 14'h0000, 1'b1, "R1");
    frame(64, 4'd9,  1'b0, 16'hAAAA, 12'hFFF, 1'b0, 14'h1234, 1'b0, 12'h000, 1'b0, 14'h3FFF, 1'b0, "R1");
    // R6 write returns previous value
    frame(64, 4'd3, 1'b1, 16'h1234, 12'h111, 1'b1, 14'h0222, 1'b1, 12'h5A5, 1'b1, 14'h0A5A, 1'b1, "R6");
    // R5 read sees the write, data field ignored
    frame(64, 4'd3, 1'b0, 16'hFFFF, 12'h222, 1'b0, 14'h0333, 1'b1, 12'h0F0, 1'b0, 14'h00F0, 1'b1, "R5");
    frame(64, 4'd3, 1'b0, 16'h0000, 12'h333, 1'b1, 14'h0444, 1'b0, 12'h00F, 1'b1, 14'h000F, 1'b0, "R5");
    // R10 repeated writes to one register
    frame(64, 4'd3, 1'b1, 16'hBEEF, 12'h444, 1'b0, 14'h0555, 1'b0, 12'h321, 1'b0, 14'h0321, 1'b0, "R10");
    frame(64, 4'd3, 1'b1, 16'hBEEF, 12'h555, 1'b0, 14'h0666, 1'b0, 12'h321, 1'b0, 14'h0321, 1'b0, "R10");
    frame(64, 4'd3, 1'b1, 16'h0001, 12'h666, 1'b0, 14'h0777, 1'b0, 12'h321, 1'b0, 14'h0321, 1'b0, "R10");
    frame(64, 4'd3, 1'b0, 16'h9999, 12'h777, 1'b0, 14'h0888, 1'b0, 12'h321, 1'b0, 14'h0321, 1'b0, "R10");
    // R9 cut-short write frames commit nothing
    frame(63, 4'd3, 1'b1, 16'hFFFF, 12'h000, 1'b0, 14'h0000, 1'b0, 12'h000, 1'b0, 14'h0000, 1'b0, "R9");
    frame(50, 4'd3, 1'b1, 16'hFFFF, 12'h000, 1'b0, 14'h0000, 1'b0, 12'h000, 1'b0, 14'h0000, 1'b0, "R9");
    frame(64, 4'd3, 1'b0, 16'h0000, 12'hC3C, 1'b1, 14'h3C3C, 1'b1, 12'hA0A, 1'b1, 14'h0A0A, 1'b1, "R9");
    // R6 edge addresses written then read back
    frame(64, 4'd15, 1'b1, 16'h8001, 12'h000, 1'b0, 14'h0000, 1'b0, 12'h000, 1'b0, 14'h0000, 1'b0, "R6");
    frame(64, 4'd0,  1'b1, 16'h7FFE, 12'h000, 1'b0, 14'h0000, 1'b0, 12'h000, 1'b0, 14'h0000, 1'b0, "R6");
    frame(64, 4'd15, 1'b0, 16'h0000, 12'h000, 1'b0, 14'h0000, 1'b0, 12'h000, 1'b0, 14'h0000, 1'b0, "R6");
    frame(64, 4'd0,  1'b0, 16'h0000, 12'h000, 1'b0, 14'h0000, 1'b0, 12'h000, 1'b0, 14'h0000, 1'b0, "R6");
    repeat (4) @(negedge clk); #1;
    cmp("R1", "sdo idle after frames", {15'd0, sdo}, 16'd0);
    // R4 every flagged sample was delivered, no others
    cmp("R4", "pending samples", 16'(aud_q.size() + tel_q.size()), 16'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule